// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block watches an I2C bus from the slave side and decides whether the first byte after a START condition addresses this device. It takes SCL and SDA samples that have already been synchronized and filtered into the system clock domain. It shifts in the address byte and compares its upper seven bits with a programmed device address. When general-call acceptance is switched on, it also accepts the all-zero byte. On a hit it drives an acknowledge, raises an addressed flag and presents the direction bit. It also keeps the matched byte readable, so the controller can tell a general call from a direct hit.

While the block stays addressed in a write transfer, it keeps acknowledging the following data bytes as a slave receiver. A transfer-complete flag marks the end of every byte the block takes part in. The SDA output is an open-drain style pull request. The block only requests SDA low and never drives it high. While the enable input is low the block is fully quiet.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset, and on every cycle that follows a cycle with `enable` low, `sda_pull_o`, `aas_o`, `srw_o` and `tcf_o` are 0. While `enable` is low, no byte is acknowledged.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A STOP clears `aas_o` and ends the transfer.
- R3: Bits are sampled on SCL rising edges, most significant bit first, and the eighth bit is R/W. On a match, `addr_byte_o` holds the whole byte (7-bit address in bits 7:1, R/W in bit 0). It keeps that value after the transfer ends.
- R4: When bits 7:1 of the first byte after START equal `own_addr_i`, `sda_pull_o` goes to 1 after the SCL falling edge that ends the eighth bit. It stays 1 through the whole ninth SCL high period and returns to 0 after the ninth falling edge.
- R5: A first byte that matches neither the own address nor an enabled general call gets no acknowledge. `aas_o` and `tcf_o` stay 0 for that transfer, including its data bytes.
- R6: With `gc_en_i` at 1, a first byte of 0x00 is acknowledged. `aas_o` goes to 1, `srw_o` is 0 and `addr_byte_o` reads 0x00.
- R7: With `gc_en_i` at 0, a first byte of 0x00 gets no acknowledge, and neither does any data byte that follows it.
- R8: `aas_o` goes to 1 in the same cycle the acknowledge request starts, which is the falling edge after the eighth bit of a matching address.
- R9: On a match, `srw_o` takes the value of the eighth received bit (1 = master reads, 0 = master writes).
- R10: `tcf_o` goes to 1 after the falling edge of the ninth SCL clock of every byte while the block is addressed. It clears on the next SCL rising edge that starts a byte, or on a START or STOP.
- R11: While the block is addressed with R/W = 0, every data byte is acknowledged during its ninth clock.
- R12: A repeated START clears `aas_o` and evaluates the next byte as a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable. Low keeps every output quiet |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| own_addr_i | input | ADDR_W | Programmed 7-bit device address |
| gc_en_i | input | 1 | Accept the all-zero general-call byte |
| sda_pull_o | output | 1 | Request to pull SDA low (acknowledge) |
| aas_o | output | 1 | Addressed-as-slave flag |
| srw_o | output | 1 | Captured R/W bit of the matched address |
| tcf_o | output | 1 | Byte transfer complete flag |
| addr_byte_o | output | ADDR_W+1 | Last matched address byte |

## Verification
Two things happen on the same SCL falling edge at the end of each ninth clock. The acknowledge request is released, and the transfer-complete flag is raised. The bench samples one clock after that edge and expects `sda_pull_o` low and `tcf_o` high together. The addressed flag and the acknowledge request also start on one common edge, the fall after the eighth bit. The bench checks the pull request before the ninth rise, checks the line level during the ninth high phase, and reads the flags in between. Repeated START and general calls with acceptance switched off are driven as separate scenarios, so that a wrong acknowledge shows up on the bus level.

// File: rtl/i2cam_pkg.sv
package i2cam_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2
   } phase_t;
endpackage

// File: rtl/i2cam_edge_det.sv
module i2cam_edge_det #(
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q;
   logic sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= IDLE_LVL;
         sda_q <= IDLE_LVL;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   always_comb begin
      scl_rise  = scl & ~scl_q;
      scl_fall  = ~scl & scl_q;
      start_det = scl & scl_q & sda_q & ~sda;
      stop_det  = scl & scl_q & ~sda_q & sda;
   end
endmodule

// File: rtl/i2cam_bit_shifter.sv
module i2cam_bit_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda,
   output logic [BYTE_W-1:0] byte_q,
   output logic              byte_full,
   output logic              ninth_fall,
   output logic              first_rise
);
   localparam int SLOTS = BYTE_W + 1;
   localparam int CNT_W = $clog2(SLOTS + 1);
   localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BYTE_W);
   localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         byte_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (scl_rise) begin
         if (cnt_q < LAST_SLOT) cnt_q <= cnt_q + 1'b1;
         if (cnt_q < LAST_DATA) byte_q <= {byte_q[BYTE_W-2:0], sda};
      end else if (scl_fall && cnt_q == LAST_SLOT) begin
         cnt_q <= '0;
      end
   end

   always_comb begin
      byte_full  = scl_fall && (cnt_q == LAST_DATA) && !clr;
      ninth_fall = scl_fall && (cnt_q == LAST_SLOT) && !clr;
      first_rise = scl_rise && (cnt_q == '0);
   end
endmodule

// File: rtl/i2cam_addr_cmp.sv
module i2cam_addr_cmp #(
   parameter int ADDR_W = 7,
   parameter logic [ADDR_W:0] GC_CODE = '0
) (
   input  logic [ADDR_W:0]   byte_i,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              gc_en,
   output logic              own_hit,
   output logic              gc_hit
);
   always_comb begin
      own_hit = (byte_i[ADDR_W:1] == own_addr);
      gc_hit  = gc_en && (byte_i == GC_CODE);
   end
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match
   import i2cam_pkg::*;
#(
   parameter int   ADDR_W   = 7,
   parameter logic ACK_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              gc_en_i,
   output logic              sda_pull_o,
   output logic              aas_o,
   output logic              srw_o,
   output logic              tcf_o,
   output logic [ADDR_W:0]   addr_byte_o
);
   localparam int BYTE_W = ADDR_W + 1;
   localparam logic [BYTE_W-1:0] GC_CODE = '0;

   if (ADDR_W != 7) begin : g_bad_width
      $error("i2c_addr_match: ADDR_W must be 7");
   end

   logic scl_rise, scl_fall, start_det, stop_det;
   logic clr;
   logic [BYTE_W-1:0] byte_q;
   logic byte_full, ninth_fall, first_rise;
   logic own_hit, gc_hit, hit;
   logic data_ack;
   phase_t phase_q;
   logic addressed_q, srw_q, ack_q, tcf_q;
   logic [BYTE_W-1:0] abyte_q;

   i2cam_edge_det #(.IDLE_LVL(1'b1)) u_edge (
      .clk(clk), .rst_n(rst_n), .scl(scl_i), .sda(sda_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   assign clr = !enable || start_det || stop_det;

   i2cam_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda(sda_i),
      .byte_q(byte_q), .byte_full(byte_full),
      .ninth_fall(ninth_fall), .first_rise(first_rise)
   );

   i2cam_addr_cmp #(.ADDR_W(ADDR_W), .GC_CODE(GC_CODE)) u_cmp (
      .byte_i(byte_q), .own_addr(own_addr_i), .gc_en(gc_en_i),
      .own_hit(own_hit), .gc_hit(gc_hit)
   );

   assign hit = own_hit || gc_hit;

   if (ACK_DATA) begin : g_rx_ack
      assign data_ack = addressed_q && !srw_q;
   end else begin : g_no_rx_ack
      assign data_ack = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         addressed_q <= 1'b0;
         srw_q       <= 1'b0;
         ack_q       <= 1'b0;
         tcf_q       <= 1'b0;
         abyte_q     <= '0;
      end else if (!enable || stop_det) begin
         phase_q     <= PH_IDLE;
         addressed_q <= 1'b0;
         srw_q       <= 1'b0;
         ack_q       <= 1'b0;
         tcf_q       <= 1'b0;
      end else if (start_det) begin
         phase_q     <= PH_ADDR;
         addressed_q <= 1'b0;
         srw_q       <= 1'b0;
         ack_q       <= 1'b0;
         tcf_q       <= 1'b0;
      end else begin
         if (first_rise) tcf_q <= 1'b0;
         if (byte_full) begin
            if (phase_q == PH_ADDR && hit) begin
               addressed_q <= 1'b1;
               srw_q       <= byte_q[0];
               abyte_q     <= byte_q;
               ack_q       <= 1'b1;
            end else if (phase_q == PH_DATA && data_ack) begin
               ack_q <= 1'b1;
            end
         end
         if (ninth_fall) begin
            ack_q <= 1'b0;
            if (addressed_q) tcf_q <= 1'b1;
            if (phase_q == PH_ADDR)
               phase_q <= addressed_q ? PH_DATA : PH_IDLE;
         end
      end
   end

   assign sda_pull_o  = ack_q;
   assign aas_o       = addressed_q;
   assign srw_o       = srw_q;
   assign tcf_o       = tcf_q;
   assign addr_byte_o = abyte_q;

   AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!sda_pull_o && !aas_o && !tcf_o)); // R1
   AST_STOP_CLEARS_AAS: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && stop_det) |=> !aas_o); // R2
   AST_AAS_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aas_o) |-> sda_pull_o); // R8
   AST_GC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(aas_o) && addr_byte_o == GC_CODE && own_addr_i != '0) |-> gc_en_i); // R7
   AST_GC_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (aas_o && addr_byte_o == GC_CODE) |-> !srw_o); // R6
   AST_TCF_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tcf_o) |-> !scl_i); // R10
   AST_REPSTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !aas_o); // R12
endmodule

// File: tb/i2c_addr_match_tb.sv
module i2c_addr_match_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic [6:0] own_addr = 7'h2A;
   logic gc_en = 1'b0;
   logic sda_pull, aas, srw, tcf;
   logic [7:0] abyte;
   logic sda_bus;
   int n_chk = 0;
   int n_err = 0;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_pull;

   i2c_addr_match dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .scl_i(scl_m), .sda_i(sda_bus),
      .own_addr_i(own_addr), .gc_en_i(gc_en),
      .sda_pull_o(sda_pull), .aas_o(aas), .srw_o(srw), .tcf_o(tcf),
      .addr_byte_o(abyte)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_start();
      sda_m = 1'b1; wt(4);
      scl_m = 1'b1; wt(4);
      sda_m = 1'b0; wt(4);
      scl_m = 1'b0; wt(4);
   endtask

   task automatic do_stop();
      sda_m = 1'b0; wt(4);
      scl_m = 1'b1; wt(4);
      sda_m = 1'b1; wt(4);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; wt(4);
      scl_m = 1'b1; wt(8);
      scl_m = 1'b0; wt(4);
   endtask

   // Sends eight bits then the ninth clock; pre = pull before ninth rise,
   // acked = bus low in ninth high period. Returns one clock after ninth fall.
   task automatic xfer(input logic [7:0] b, output logic pre, output logic acked);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      pre = sda_pull;
      sda_m = 1'b1; wt(4);
      scl_m = 1'b1; wt(4);
      acked = ~sda_bus;
      wt(4);
      scl_m = 1'b0; wt(1);
   endtask

   task automatic t_reset();
      chk("R1 reset pull", sda_pull, 0);
      chk("R1 reset aas", aas, 0);
      chk("R1 reset tcf", tcf, 0);
      chk("R1 reset srw", srw, 0);
   endtask

   task automatic t_disabled();
      logic p, a;
      enable = 1'b0;
      do_start();
      xfer({7'h2A, 1'b0}, p, a);
      chk("R1 disabled ack", a, 0);
      chk("R1 disabled aas", aas, 0);
      wt(3); do_stop();
      enable = 1'b1; wt(2);
   endtask

   task automatic t_own_write();
      logic p, a;
      do_start();
      xfer({7'h2A, 1'b0}, p, a);
      chk("R4 pull before ninth rise", p, 1);
      chk("R4 ack on bus", a, 1);
      chk("R4 pull released", sda_pull, 0);
      chk("R8 aas set", aas, 1);
      chk("R9 srw write", srw, 0);
      chk("R3 addr byte", abyte, 8'h54);
      chk("R10 tcf after address", tcf, 1);
      wt(3);
      xfer(8'hA5, p, a);
      chk("R11 data ack", a, 1);
      chk("R10 tcf after data", tcf, 1);
      wt(3);
      send_bit(1'b1);
      chk("R10 tcf cleared", tcf, 0);
      do_stop();
      chk("R2 stop clears aas", aas, 0);
      chk("R3 byte kept", abyte, 8'h54);
   endtask

   task automatic t_own_read();
      logic p, a;
      do_start();
      xfer({7'h2A, 1'b1}, p, a);
      chk("R4 read ack", a, 1);
      chk("R9 srw read", srw, 1);
      chk("R3 read byte", abyte, 8'h55);
      wt(3); do_stop();
   endtask

   task automatic t_mismatch();
      logic p, a;
      do_start();
      xfer({7'h15, 1'b0}, p, a);
      chk("R5 no ack", a, 0);
      chk("R5 no aas", aas, 0);
      chk("R5 no tcf", tcf, 0);
      wt(3);
      xfer(8'h00, p, a);
      chk("R5 data no ack", a, 0);
      wt(3); do_stop();
   endtask

   task automatic t_gc_on();
      logic p, a;
      gc_en = 1'b1;
      do_start();
      xfer(8'h00, p, a);
      chk("R6 gc ack", a, 1);
      chk("R6 gc aas", aas, 1);
      chk("R6 gc srw", srw, 0);
      chk("R6 gc byte", abyte, 8'h00);
      wt(3);
      xfer(8'h3C, p, a);
      chk("R11 gc data ack", a, 1);
      wt(3); do_stop();
      gc_en = 1'b0;
   endtask

   task automatic t_gc_off();
      logic p, a;
      do_start();
      xfer(8'h00, p, a);
      chk("R7 gc off no ack", a, 0);
      chk("R7 gc off no aas", aas, 0);
      wt(3);
      xfer(8'h81, p, a);
      chk("R7 gc off data no ack", a, 0);
      wt(3); do_stop();
   endtask

   task automatic t_rep_start();
      logic p, a;
      do_start();
      xfer({7'h2A, 1'b0}, p, a);
      chk("R12 first ack", a, 1);
      wt(3);
      do_start();
      chk("R12 aas cleared", aas, 0);
      xfer({7'h33, 1'b0}, p, a);
      chk("R12 new addr no ack", a, 0);
      wt(3);
      do_start();
      xfer({7'h2A, 1'b1}, p, a);
      chk("R12 readdressed", aas, 1);
      chk("R2 srw after restart", srw, 1);
      wt(3); do_stop();
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      wt(4);
      rst_n = 1'b1;
      wt(2);
      t_reset();
      t_disabled();
      t_own_write();
      t_own_read();
      t_mismatch();
      t_gc_on();
      t_gc_off();
      t_rep_start();
      summary();
      $finish;
   end
endmodule